// File: doc/BRIEF.md
# Display Pixel Serializer

This block sits between a word FIFO and the pixel pipeline of a display controller. It accepts 32-bit memory words over a valid/ready handshake and emits one pixel per handshake on a valid/ready output. Each pixel is right-aligned and zero-extended on a 24-bit bus. A depth code picks a pixel width of 1, 2, 4, 8, 16 or 24 bits. An ordering bit picks which end of each word supplies the first pixel.

For 24-bit pixels, a layout bit picks between two forms. In the unpacked form each word carries exactly one pixel. In the packed form three words carry four pixels, so some pixels cross a word boundary. Bits that are not yet used stay in an internal bit buffer and are joined with the next word. The configuration is latched only while that buffer is empty, so a word is always sliced with a single setting.

Top module: `pix_serializer`

## Requirements
- R1: `cfg_depth` selects the pixel width. Code 0 gives 1 bit, 1 gives 2, 2 gives 4, 3 gives 8, 4 gives 16 and 5 gives 24. Codes 6 and 7 behave as 24. Outside the packed 24-bit mode, a word yields exactly 32/width pixels.
- R2: With `cfg_big`=0, pixel k of a word is taken from bits [k*w+w-1 : k*w].
- R3: With `cfg_big`=1, pixel k of a word is taken from bits [31-k*w : 32-(k+1)*w].
- R4: In 24-bit mode with `cfg_packed`=0, each word yields one pixel equal to bits 23:0, for either ordering. Bits 31:24 have no effect on the output.
- R5: In packed 24-bit mode with `cfg_big`=0, words A, B, C yield four pixels in this order: A[23:0], {B[15:0],A[31:24]}, {C[7:0],B[31:16]}, C[31:8].
- R6: In packed 24-bit mode with `cfg_big`=1, words A, B, C yield four pixels in this order: A[31:8], {A[7:0],B[31:16]}, {B[15:0],C[31:24]}, C[23:0].
- R7: Output bits at and above the pixel width are zero whenever `out_valid` is 1.
- R8: While `out_valid`=1 and `out_ready`=0, `out_valid` stays 1 and `out_pixel` holds its value on the next cycle.
- R9: `in_ready` is 1 only when the buffer holds fewer bits than one pixel. `out_valid` is 1 only when it holds at least one pixel. The two are never 1 together. An accepted word makes `out_valid` 1 on the next cycle. After the last pixel of a word drains (non-packed modes), `out_valid` is 0 and `in_ready` is 1.
- R10: Configuration inputs take effect only while the buffer is empty. A change while bits are held does not alter how those bits are sliced.
- R11: While reset is asserted, `out_valid` is 0 and `in_ready` is 1. Reset discards held bits, so the first pixel after reset comes only from the next word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_depth | input | 3 | Pixel depth code |
| cfg_big | input | 1 | 1: first pixel from the high end of a word |
| cfg_packed | input | 1 | 1: packed 24-bit layout |
| in_valid | input | 1 | Word available |
| in_ready | output | 1 | Block can take a word |
| in_word | input | WORD_W | Memory word |
| out_valid | output | 1 | Pixel available |
| out_ready | input | 1 | Consumer takes the pixel |
| out_pixel | output | PIX_W | Right-aligned, zero-extended pixel |

## Verification
The assertions assume that `in_valid`, `out_ready` and the configuration inputs are never unknown after reset. They also assume that a word is offered only after the two-cycle internal reset release. The stall and zero-extension properties need nothing more of the inputs, because they depend only on held state. The bench drives every input at falling edges, waits several cycles after each reset release before offering words, and changes configuration only at chosen points, including once deliberately in the middle of a word.

// File: rtl/pixser_pkg.sv
package pixser_pkg;

  localparam int unsigned DEPTH_CODE_W = 3;

  typedef enum logic [DEPTH_CODE_W-1:0] {
    DEP_1B  = 3'd0,
    DEP_2B  = 3'd1,
    DEP_4B  = 3'd2,
    DEP_8B  = 3'd3,
    DEP_16B = 3'd4,
    DEP_24B = 3'd5
  } depth_e;

  // Width in bits for a depth code; unlisted codes map to 24.
  function automatic logic [4:0] depth_width(input logic [DEPTH_CODE_W-1:0] code);
    case (code)
      DEP_1B:  depth_width = 5'd1;
      DEP_2B:  depth_width = 5'd2;
      DEP_4B:  depth_width = 5'd4;
      DEP_8B:  depth_width = 5'd8;
      DEP_16B: depth_width = 5'd16;
      default: depth_width = 5'd24;
    endcase
  endfunction

endpackage

// File: rtl/pixser_cfg.sv
module pixser_cfg #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle,
  input  logic [2:0]       depth_i,
  input  logic             big_i,
  input  logic             packed_i,
  output logic [CNT_W-1:0] width_o,
  output logic             big_o,
  output logic             packed_o
);
  import pixser_pkg::*;

  logic [CNT_W-1:0] live_w;
  logic [CNT_W-1:0] width_q, width_d;
  logic             big_q, big_d;
  logic             packed_q, packed_d;
  logic             cfg_en;

  always_comb begin
    live_w   = CNT_W'(depth_width(depth_i));
    cfg_en   = idle;
    width_d  = width_q;
    big_d    = big_q;
    packed_d = packed_q;
    if (cfg_en) begin
      width_d  = live_w;
      big_d    = big_i;
      packed_d = packed_i;
    end
    // Live settings apply while empty; the latched copy applies once bits are held
    width_o  = idle ? live_w   : width_q;
    big_o    = idle ? big_i    : big_q;
    packed_o = idle ? packed_i : packed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q  <= CNT_W'(1);
      big_q    <= 1'b0;
      packed_q <= 1'b0;
    end else if (cfg_en) begin
      width_q  <= width_d;
      big_q    <= big_d;
      packed_q <= packed_d;
    end
  end

endmodule

// File: rtl/pixser_buf.sv
module pixser_buf #(
  parameter int WORD_W = 32,
  parameter int PIX_W  = 24,
  parameter int BUF_W  = WORD_W + PIX_W,
  parameter int CNT_W  = $clog2(BUF_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  width,
  input  logic              big,
  input  logic              packd,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PIX_W-1:0]  out_pixel,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] BUF_WC  = CNT_W'(BUF_W);
  localparam logic [CNT_W-1:0] WORD_WC = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] PIX_WC  = CNT_W'(PIX_W);

  logic [BUF_W-1:0] buf_q, buf_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             load, pop, buf_en, unpk;
  logic [CNT_W-1:0] chunk_bits, be_shift;
  logic [BUF_W-1:0] chunk_le, chunk_be;
  logic [PIX_W-1:0] mask, pix_le, pix_be;

  always_comb begin
    in_ready  = cnt_q < width;
    out_valid = cnt_q >= width;
    load      = in_valid && in_ready;
    pop       = out_valid && out_ready;
    buf_en    = load || pop;
    unpk      = (width == PIX_WC) && !packd;

    chunk_bits = unpk ? PIX_WC : WORD_WC;
    if (unpk) begin
      chunk_le = {{(BUF_W-PIX_W){1'b0}}, in_word[PIX_W-1:0]} << cnt_q;
      chunk_be = {in_word[PIX_W-1:0], {(BUF_W-PIX_W){1'b0}}} >> cnt_q;
    end else begin
      chunk_le = {{(BUF_W-WORD_W){1'b0}}, in_word} << cnt_q;
      chunk_be = {in_word, {(BUF_W-WORD_W){1'b0}}} >> cnt_q;
    end

    mask     = ~({PIX_W{1'b1}} << width);
    be_shift = BUF_WC - width;
    pix_le   = buf_q[PIX_W-1:0] & mask;
    pix_be   = PIX_W'(buf_q >> be_shift);
    out_pixel = big ? pix_be : pix_le;

    buf_d = buf_q;
    cnt_d = cnt_q;
    if (load) begin
      buf_d = buf_q | (big ? chunk_be : chunk_le);
      cnt_d = cnt_q + chunk_bits;
    end else if (pop) begin
      buf_d = big ? (buf_q << width) : (buf_q >> width);
      cnt_d = cnt_q - width;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      cnt_q <= '0;
    end else if (buf_en) begin
      buf_q <= buf_d;
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/pix_serializer.sv
module pix_serializer #(
  parameter int WORD_W = 32,
  parameter int PIX_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_depth,
  input  logic              cfg_big,
  input  logic              cfg_packed,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PIX_W-1:0]  out_pixel
);
  localparam int BUF_W = WORD_W + PIX_W;
  localparam int CNT_W = $clog2(BUF_W + 1);

  logic             rst_meta, rst_q;
  logic [CNT_W-1:0] act_w, cnt_q;
  logic             act_big, act_packed;

  // Reset asserts at once and releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  pixser_cfg #(.CNT_W(CNT_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_q),
    .idle     (cnt_q == '0),
    .depth_i  (cfg_depth),
    .big_i    (cfg_big),
    .packed_i (cfg_packed),
    .width_o  (act_w),
    .big_o    (act_big),
    .packed_o (act_packed)
  );

  pixser_buf #(.WORD_W(WORD_W), .PIX_W(PIX_W), .BUF_W(BUF_W), .CNT_W(CNT_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_q),
    .width     (act_w),
    .big       (act_big),
    .packd     (act_packed),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_word   (in_word),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_pixel (out_pixel),
    .cnt_o     (cnt_q)
  );

endmodule

// File: rtl/pixser_chk.sv
module pixser_chk #(
  parameter int PIX_W = 24,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PIX_W-1:0] out_pixel,
  input logic [CNT_W-1:0] act_w,
  input logic [CNT_W-1:0] bits_held
);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pixel)));

  assert_zero_ext_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (({8'h00, out_pixel} >> act_w) == 32'h0));

  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  assert_load_fills_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_cfg_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bits_held != '0) |=> ((bits_held == '0) || $stable(act_w)));

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_R11: assert (in_ready && !out_valid);
    end
  end

endmodule

bind pix_serializer pixser_chk #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_pixel (out_pixel),
  .act_w     (act_w),
  .bits_held (cnt_q)
);

// File: tb/tb_pix_serializer.sv
module tb_pix_serializer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  cfg_depth;
  logic        cfg_big, cfg_packed;
  logic        in_valid, in_ready;
  logic [31:0] in_word;
  logic        out_valid, out_ready;
  logic [23:0] out_pixel;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  pix_serializer dut (
    .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .cfg_big(cfg_big),
    .cfg_packed(cfg_packed), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_pixel(out_pixel)
  );

  localparam logic [31:0] W = 32'hE12A_3B4D;

  // {depth, big, packed, word, first pixel, pixel count}
  localparam logic [66:0] VEC [0:12] = '{
    {3'd0, 1'b0, 1'b0, W, 24'h000001, 6'd32},
    {3'd0, 1'b1, 1'b0, W, 24'h000001, 6'd32},
    {3'd1, 1'b0, 1'b0, W, 24'h000001, 6'd16},
    {3'd1, 1'b1, 1'b0, W, 24'h000003, 6'd16},
    {3'd2, 1'b0, 1'b0, W, 24'h00000D, 6'd8},
    {3'd2, 1'b1, 1'b0, W, 24'h00000E, 6'd8},
    {3'd3, 1'b0, 1'b0, W, 24'h00004D, 6'd4},
    {3'd3, 1'b1, 1'b0, W, 24'h0000E1, 6'd4},
    {3'd4, 1'b0, 1'b0, W, 24'h003B4D, 6'd2},
    {3'd4, 1'b1, 1'b0, W, 24'h00E12A, 6'd2},
    {3'd5, 1'b0, 1'b0, W, 24'h2A3B4D, 6'd1},
    {3'd5, 1'b1, 1'b0, W, 24'h2A3B4D, 6'd1},
    {3'd6, 1'b0, 1'b0, W, 24'h2A3B4D, 6'd1}
  };

  task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] model(input logic [31:0] wd, input int w, input bit be, input int k);
    logic [31:0] m;
    if (w == 24) return wd[23:0];
    m = (32'h1 << w) - 32'h1;
    if (be) return 24'((wd >> (32 - (k + 1) * w)) & m);
    return 24'((wd >> (k * w)) & m);
  endfunction

  task automatic push(input logic [31:0] wd);
    in_word  = wd;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pull(input logic [23:0] exp, input string req);
    out_ready = 1'b1;
    while (!out_valid) @(negedge clk);
    chk(out_pixel == exp, req, out_pixel, exp);
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic set_cfg(input logic [2:0] d, input bit be, input bit pk);
    cfg_depth = d; cfg_big = be; cfg_packed = pk;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(in_ready && !out_valid, "R11 reset outputs", {22'h0, in_ready, out_valid}, 24'h2);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_word = '0; out_ready = 1'b0;
    set_cfg(3'd0, 1'b0, 1'b0);
    @(negedge clk);
    do_reset();

    // Table walk: R1 width and count, R2/R3 ordering, R4 unpacked, R7 zero-extension
    for (int i = 0; i < 13; i++) begin
      logic [66:0] v;
      int cnt, w;
      string ord;
      v   = VEC[i];
      cnt = int'(v[5:0]);
      w   = (cnt == 1) ? 24 : 32 / cnt;
      ord = v[63] ? "R3" : "R2";
      set_cfg(v[66:64], v[63], v[62]);
      push(v[61:30]);
      for (int k = 0; k < cnt; k++) begin
        out_ready = 1'b1;
        while (!out_valid) @(negedge clk);
        if (k == 0) chk(out_pixel == v[29:6], "R1 first pixel", out_pixel, v[29:6]);
        chk(out_pixel == model(v[61:30], w, v[63], k), (cnt == 1) ? "R4" : ord,
            out_pixel, model(v[61:30], w, v[63], k));
        chk((32'(out_pixel) >> w) == 0, "R7 upper bits", out_pixel, 24'h0);
        @(negedge clk);
        out_ready = 1'b0;
      end
      chk(!out_valid && in_ready, "R9 drained after count", {22'h0, out_valid, in_ready}, 24'h1);
    end

    // R5 packed little-endian
    set_cfg(3'd5, 1'b0, 1'b1);
    push(32'h1122_3344); pull(24'h223344, "R5 p0");
    push(32'h5566_7788); pull(24'h778811, "R5 p1");
    push(32'h99AA_BBCC); pull(24'hCC5566, "R5 p2");
    pull(24'h99AABB, "R5 p3");
    chk(!out_valid && in_ready, "R5 empty after group", {22'h0, out_valid, in_ready}, 24'h1);

    // R6 packed big-endian
    set_cfg(3'd5, 1'b1, 1'b1);
    push(32'h1122_3344); pull(24'h112233, "R6 p0");
    push(32'h5566_7788); pull(24'h445566, "R6 p1");
    push(32'h99AA_BBCC); pull(24'h778899, "R6 p2");
    pull(24'hAABBCC, "R6 p3");

    // R8 backpressure hold
    set_cfg(3'd3, 1'b0, 1'b0);
    push(W);
    for (int c = 0; c < 3; c++) begin
      chk(out_valid && out_pixel == 24'h4D, "R8 held", out_pixel, 24'h4D);
      @(negedge clk);
    end
    pull(24'h4D, "R8 released"); pull(24'h3B, "R8"); pull(24'h2A, "R8"); pull(24'hE1, "R8");

    // R10 config change mid-word is ignored until empty
    set_cfg(3'd3, 1'b0, 1'b0);
    push(W);
    pull(24'h4D, "R10 first");
    set_cfg(3'd0, 1'b1, 1'b0);
    pull(24'h3B, "R10 locked"); pull(24'h2A, "R10 locked"); pull(24'hE1, "R10 locked");
    push(W);
    for (int k = 0; k < 32; k++) pull(model(W, 1, 1'b1, k), "R10 new cfg");

    // R11 reset discards residue
    set_cfg(3'd5, 1'b0, 1'b1);
    push(32'h1122_3344); pull(24'h223344, "R11 pre");
    do_reset();
    set_cfg(3'd3, 1'b0, 1'b0);
    push(32'h5566_7788);
    pull(24'h88, "R11 no residue"); pull(24'h77, "R11"); pull(24'h66, "R11"); pull(24'h55, "R11");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule